// File: doc/BRIEF.md
# Symmetric 51-Tap Fixed-Point FIR Filter

This block is a real-valued, linear-phase FIR filter in direct form. On every rising clock edge where the enable is high, it accepts one signed 16-bit sample. The sample is a fraction with 15 fractional bits. The block multiplies the current sample and the 50 previous samples by a fixed set of symmetric coefficients, sums the products without losing any bits, and registers a signed 16-bit result.

The coefficients are signed 16-bit fractions with 16 fractional bits. Each product keeps all 32 bits, with 31 fractional bits. The products are summed in a 40-bit accumulator that also has 31 fractional bits. The accumulator is reduced to the output format by floor rounding, which is a plain drop of low bits. The default output keeps 31 fractional bits, so no bits are dropped and only the clamp acts. The clamp limits the result to the most positive or most negative 16-bit code.

The current input feeds tap 0 directly, with no input register. The delay line and the output register both update only on enabled edges. The coefficient set is a compile-time parameter. Because the set is symmetric, the default build adds each pair of mirror-image samples before multiplying, so it needs only 26 multipliers instead of 51.

Top module: `fir_direct`

## Requirements
- R1: While `rst` is high at a rising edge, the output register and all 50 delay registers clear to zero. After release, a zero input stream keeps `y_out` at 0x0000.
- R2: After each enabled edge, `y_out` equals clamp(sum over k=0..50 of c[k]·x[n−k]) in units of 2^-31. Here x[n] is the value on `x_in` at that edge, and x[n−k] is the value accepted k enabled edges earlier.
- R3: The default coefficients are c[k] = min(k, 50−k) − 12, in units of 2^-16, and they are symmetric. An impulse of amplitude A followed by zeros produces clamp(A·c[k]) after the k-th enabled edge, counting the impulse edge as k = 0.
- R4: A full-scale impulse of 0x7FFF followed by zeros produces clamp(32767·c[k]). This gives 0x0000 at k = 12 and k = 38, where c[k] is 0.
- R5: A sum above 32767 gives `y_out` = 0x7FFF and does not wrap.
- R6: A sum below −32768 gives `y_out` = 0x8000 and does not wrap.
- R7: On an edge where `en` is low, neither `y_out` nor the delay line changes, and the value on `x_in` never enters the delay line.
- R8: A constant input A settles, from the 51st enabled edge on, to clamp(13·A), since the default coefficients sum to 13.
- R9: Full-range inputs, including −32768, produce exact products and an exact 40-bit sum, with no intermediate wrap before the output clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable: sample accepted and output updated when high |
| x_in | input | 16 | Signed sample, 15 fractional bits |
| y_out | output | 16 | Registered signed result, 31 fractional bits |

## Verification
Four input patterns are used:
- **Impulses** at amplitudes 1, 700 and 0x7FFF read the coefficients back one at a time. They separate a wrong tap order or tap count from a wrong coefficient value, and at full scale they show clamping of individual taps.
- **Constant steps** swept across −2600..2600 settle at 13·A. The sweep includes the amplitudes ±2520 and ±2521 on each side of the clamp boundary, which show whether the positive and negative limits trip at exactly the right sum.
- **Ramps and small pseudo-random streams** stay inside the output range. They expose any error in the multiply and accumulate path.
- **Full-range pseudo-random streams** and stretches with a random enable check that the sum never wraps, and that samples presented while disabled never reach the delay line.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int FIR_TAPS = 51;
    localparam int FIR_SW   = 16;
    localparam int FIR_CW   = 16;

    // Symmetric triangle centred on zero: c[k] = min(k, N-1-k) - N/4
    function automatic logic [FIR_TAPS*FIR_CW-1:0] default_coefs();
        logic [FIR_TAPS*FIR_CW-1:0] v;
        v = '0;
        for (int k = 0; k < FIR_TAPS; k++) begin
            int m;
            m = (k < FIR_TAPS - 1 - k) ? k : FIR_TAPS - 1 - k;
            v[k*FIR_CW +: FIR_CW] = FIR_CW'(m - FIR_TAPS / 4);
        end
        return v;
    endfunction

endpackage

// File: rtl/fir_tap_sum.sv
module fir_tap_sum #(
    parameter int NTAPS = 51,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int AW    = 40,
    parameter bit FOLD  = 1'b1,
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  logic [NTAPS-1:0][DW-1:0] taps,
    output logic signed [AW-1:0]     acc
);
    localparam int PW    = DW + CW;
    localparam int NPAIR = NTAPS / 2;
    localparam bit ODD   = (NTAPS % 2) == 1;
    localparam int NPROD = FOLD ? (NPAIR + (ODD ? 1 : 0)) : NTAPS;

    logic signed [PW:0] prod [NPROD];

    generate
        if (FOLD) begin : g_fold
            for (genvar k = 0; k < NPAIR; k++) begin : g_pair
                logic signed [DW:0] pre_sum;
                assign pre_sum = (DW+1)'($signed(taps[k])) + (DW+1)'($signed(taps[NTAPS-1-k]));
                assign prod[k] = (PW+1)'(pre_sum) * (PW+1)'($signed(COEFS[k*CW +: CW]));
            end
            if (ODD) begin : g_mid
                assign prod[NPAIR] = (PW+1)'($signed(taps[NPAIR]))
                                   * (PW+1)'($signed(COEFS[NPAIR*CW +: CW]));
            end
        end else begin : g_flat
            for (genvar k = 0; k < NTAPS; k++) begin : g_tap
                assign prod[k] = (PW+1)'($signed(taps[k])) * (PW+1)'($signed(COEFS[k*CW +: CW]));
            end
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int k = 0; k < NPROD; k++) begin
            acc = acc + AW'(prod[k]);
        end
    end

endmodule

// File: rtl/fir_quant.sv
module fir_quant #(
    parameter int AW    = 40,
    parameter int OW    = 16,
    parameter int SHIFT = 0
) (
    input  logic signed [AW-1:0] acc,
    output logic [OW-1:0]        q
);
    localparam logic signed [AW-1:0] QMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW-1:0] QMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

    logic signed [AW-1:0] floored;

    always_comb begin
        floored = acc >>> SHIFT;
        if (floored > QMAX) begin
            q = QMAX[OW-1:0];
        end else if (floored < QMIN) begin
            q = QMIN[OW-1:0];
        end else begin
            q = floored[OW-1:0];
        end
    end

endmodule

// File: rtl/fir_direct.sv
module fir_direct #(
    parameter int NTAPS    = fir_pkg::FIR_TAPS,
    parameter int DW       = fir_pkg::FIR_SW,
    parameter int CW       = fir_pkg::FIR_CW,
    parameter int OW       = 16,
    parameter int AW       = 40,
    parameter int ACC_FRAC = 31,
    parameter int FRAC_OUT = 31,
    parameter bit FOLD     = 1'b1,
    parameter logic [NTAPS*CW-1:0] COEFS = fir_pkg::default_coefs()
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] x_in,
    output logic [OW-1:0] y_out
);
    localparam int NDLY  = NTAPS - 1;
    localparam int SHIFT = ACC_FRAC - FRAC_OUT;

    typedef struct packed {
        logic [NDLY-1:0][DW-1:0] dly;
        logic [OW-1:0]           y;
    } state_t;

    state_t st_d, st_q;

    logic [NTAPS-1:0][DW-1:0] taps;
    logic signed [AW-1:0]     acc_w;
    logic [OW-1:0]            y_next;

    assign taps = {st_q.dly, x_in};

    fir_tap_sum #(
        .NTAPS (NTAPS),
        .DW    (DW),
        .CW    (CW),
        .AW    (AW),
        .FOLD  (FOLD),
        .COEFS (COEFS)
    ) u_sum (
        .taps (taps),
        .acc  (acc_w)
    );

    fir_quant #(
        .AW    (AW),
        .OW    (OW),
        .SHIFT (SHIFT)
    ) u_quant (
        .acc (acc_w),
        .q   (y_next)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.dly = {st_q.dly[NDLY-2:0], x_in};
            st_d.y   = y_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out = st_q.y;

    // Checks on the registered result against the raw accumulator
    localparam longint HI_LIM = (64'sd1 <<< (OW - 1)) - 64'sd1;
    localparam longint LO_LIM = -HI_LIM - 64'sd1;

    logic signed [AW-1:0] acc_sh;
    assign acc_sh = acc_w >>> SHIFT;

    a_r7_hold_out: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.y));

    a_r7_hold_dly: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q.dly));

    a_r5_pos_clamp: assert property (@(posedge clk) disable iff (rst)
        (en && (longint'(acc_sh) > HI_LIM)) |=> (y_out == {1'b0, {(OW-1){1'b1}}}));

    a_r6_neg_clamp: assert property (@(posedge clk) disable iff (rst)
        (en && (longint'(acc_sh) < LO_LIM)) |=> (y_out == {1'b1, {(OW-1){1'b0}}}));

    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        (en && (longint'(acc_sh) <= HI_LIM) && (longint'(acc_sh) >= LO_LIM))
        |=> (y_out == $past(acc_sh[OW-1:0])));

endmodule

// File: tb/fir_direct_bench.sv
module fir_direct_bench;

    localparam int N = 51;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] x   = 16'h0000;
    logic [15:0] y;

    always #10 clk = ~clk;

    fir_direct u_fir_direct (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .x_in  (x),
        .y_out (y)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint dly [N-1];
    longint exp_y = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic longint coef(int k);
        int m;
        if (k < 0 || k >= N) return 0;
        m = (k < N - 1 - k) ? k : N - 1 - k;
        return longint'(m - 12);
    endfunction

    function automatic longint clamp16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(string tag, longint act, longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [15:0] next_rand();
        lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
        return lfsr;
    endfunction

    task automatic tick(logic r, logic e, logic [15:0] v, string tag);
        longint acc;
        @(negedge clk);
        rst = r; en = e; x = v;
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < N - 1; k++) dly[k] = 0;
            exp_y = 0;
        end else if (e) begin
            acc = coef(0) * longint'($signed(v));
            for (int k = 1; k < N; k++) acc += coef(k) * dly[k-1];
            for (int k = N - 2; k > 0; k--) dly[k] = dly[k-1];
            dly[0] = longint'($signed(v));
            exp_y = clamp16(acc);
        end
        #5;
        check(tag, longint'($signed(y)), exp_y);
    endtask

    task automatic impulse(longint amp, string tag);
        tick(1'b0, 1'b1, 16'(amp), tag);
        check(tag, longint'($signed(y)), clamp16(amp * coef(0)));
        for (int k = 1; k < N + 4; k++) begin
            tick(1'b0, 1'b1, 16'h0000, tag);
            check(tag, longint'($signed(y)), clamp16(amp * coef(k)));
        end
    endtask

    task automatic step(longint amp, string tag);
        for (int k = 0; k < N + 2; k++) tick(1'b0, 1'b1, 16'(amp), tag);
        check("R8", longint'($signed(y)), clamp16(13 * amp));
    endtask

    initial begin
        // R1: reset with live inputs, then zeros
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1, 16'h1234, "R1");
        check("R1", longint'($signed(y)), 0);
        for (int i = 0; i < N + 4; i++) tick(1'b0, 1'b1, 16'h0000, "R1");

        // R3 and R4: impulses
        impulse(1, "R3");
        impulse(700, "R3");
        impulse(-3, "R3");
        impulse(32767, "R4");

        // R8, R5, R6: step sweep across the clamp boundary
        for (int a = -2600; a <= 2600; a += 200) step(a, "R8");
        step(2520, "R5");
        step(2521, "R5");
        step(-2520, "R6");
        step(-2521, "R6");
        step(32767, "R5");
        step(-32768, "R6");

        // R2: ramp and small random
        for (int i = 0; i < 150; i++) tick(1'b0, 1'b1, 16'(i * 37 - 2500), "R2");
        for (int i = 0; i < 300; i++) tick(1'b0, 1'b1, 16'($signed(next_rand()) >>> 5), "R2");

        // R9: full-range random
        for (int i = 0; i < 300; i++) tick(1'b0, 1'b1, next_rand(), "R9");

        // R7: hold with disabled edges, then random enable
        begin
            longint held;
            held = longint'($signed(y));
            for (int i = 0; i < 6; i++) begin
                tick(1'b0, 1'b0, 16'h7FFF, "R7");
                check("R7", longint'($signed(y)), held);
            end
        end
        for (int i = 0; i < 400; i++) begin
            logic [15:0] r;
            r = next_rand();
            tick(1'b0, r[3] ^ r[9], 16'($signed(next_rand()) >>> 4), "R7");
        end
        for (int i = 0; i < N + 2; i++) tick(1'b0, 1'b1, 16'h0000, "R7");
        check("R7", longint'($signed(y)), 0);

        // R1: reset mid-stream
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, 16'h3000, "R1");
        tick(1'b1, 1'b1, 16'h3000, "R1");
        check("R1", longint'($signed(y)), 0);
        for (int i = 0; i < N; i++) tick(1'b0, 1'b1, 16'h0000, "R1");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished (R2)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule